// File: doc/BRIEF.md
# Oversampling Nine-Bit Serial Receiver

This block receives asynchronous frames of eleven bit times: a low start bit, eight data bits sent least significant first, a ninth bit, and a final stop bit. The line is sampled only on clock cycles where a sample-enable strobe is high. That strobe runs at sixteen times the bit rate. The line first passes through a two-flop synchronizer. When the block is idle and enabled, a high-to-low transition seen between two consecutive samples starts a reception. The same transition restarts the phase counter, which divides each bit time into sixteen sample slots. Each bit is then decided from the samples in slots 8, 9 and 10: the value taken by at least two of the three wins.

If the first decided bit is not low, the transition was a glitch. The frame is dropped and the block resumes hunting for a falling edge. Otherwise the block collects the eight data bits and the ninth bit, then decides the stop bit. At that final decision the frame is accepted only if two conditions hold. First, the done flag is currently clear. Second, either the address-filter input is low or the stop bit reads high. An accepted frame loads the byte register and the ninth-bit register and raises the done flag. A discarded frame leaves all three untouched. The done flag stays high until the clear input is pulsed.

Top module: `serial9_rx`

## Requirements
- R1: In reset and directly after it, `rx_data` is 0, `rx_bit9` is 0 and `rx_done` is 0.
- R2: The line is synchronized through two flops, and the sample that first reads low after a high sample is phase 0 of the start bit. With a sample strobe every clock, `rx_done` rises 173 clock edges after the first edge at which the low start level is on `rxd`. Frames are also received correctly when the strobe is slower than the clock.
- R3: Each bit value is the majority of the samples at phases 8, 9 and 10 of that bit, so a single wrong sample at one of those phases does not change the received value.
- R4: If the start bit decides high, the reception is abandoned without any output change, and a later valid frame is received normally.
- R5: A frame is start bit 0, then data bits 0 through 7, then the ninth bit, then the stop bit. On acceptance `rx_data` holds the eight data bits, with data bit 0 in `rx_data[0]`, and `rx_bit9` holds the ninth bit.
- R6: A frame that ends while `rx_done` is 1 is discarded, and `rx_data` and `rx_bit9` keep their values.
- R7: With `mp_filter` at 1, a frame whose stop bit decides 0 is discarded, and one whose stop bit decides 1 is accepted. With `mp_filter` at 0, the stop bit value does not matter.
- R8: `rx_done` stays at 1 until `done_clr` is high at a clock edge, and it is 0 after that edge.
- R9: While `rx_en` is 0 no reception starts, and dropping `rx_en` during a frame abandons that frame with no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe at sixteen times the bit rate |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line, idle high |
| mp_filter | input | 1 | When high, only frames whose stop bit reads 1 are accepted |
| done_clr | input | 1 | Clears the done flag |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_done | output | 1 | Set when a frame is accepted |

## Verification
With a strobe on every clock, the done flag is due 173 clock edges after the start level reaches the pin. That count is two synchronizer flops, one detecting edge and 170 sample ticks up to phase 10 of the stop bit. The bench stamps the drive cycle and the rise cycle with a free-running counter and compares the difference against that sum. Every other frame check samples at a falling clock edge only after the whole frame and sixteen idle bit slots have gone by, so the result is already settled. The effect of a clear pulse is checked at the falling edge that follows the single rising edge where the pulse is seen.

// File: rtl/serial9_rx_pkg.sv
package serial9_rx_pkg;
  typedef enum logic {RX_IDLE, RX_RECV} rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/serial9_rx_sync.sv
module serial9_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial9_rx_vote.sv
module serial9_rx_vote
  import serial9_rx_pkg::*;
#(
  parameter int OVS = 16,
  localparam int CW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] phase,
  input  logic          din,
  output logic          bit_rdy,
  output logic          bit_val
);
  localparam int MID = OVS / 2;

  logic smp_a, smp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else if (tick) begin
      if (phase == CW'(MID))     smp_a <= din;
      if (phase == CW'(MID + 1)) smp_b <= din;
    end
  end

  assign bit_rdy = tick && (phase == CW'(MID + 2));
  assign bit_val = maj3(smp_a, smp_b, din);
endmodule

// File: rtl/serial9_rx_ctrl.sv
module serial9_rx_ctrl
  import serial9_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  localparam int CW    = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              line,
  input  logic              mp_filter,
  input  logic              done_clr,
  input  logic              bit_rdy,
  input  logic              bit_val,
  output logic [CW-1:0]     phase,
  output logic              busy,
  output logic [DATA_W-1:0] data_q,
  output logic              bit9_q,
  output logic              done_q
);
  localparam int NBITS    = DATA_W + 3;
  localparam int IW       = $clog2(NBITS);
  localparam int STOP_IDX = NBITS - 1;

  rx_state_e     state;
  logic [IW-1:0] idx;
  logic          prev;
  logic [DATA_W:0] shreg;
  logic          at_stop, load_now;

  assign at_stop  = (state == RX_RECV) && bit_rdy && (idx == IW'(STOP_IDX));
  assign load_now = rx_en && at_stop && !done_q && (!mp_filter || bit_val);
  assign busy     = (state == RX_RECV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      phase <= '0;
      idx   <= '0;
      prev  <= 1'b1;
      shreg <= '0;
    end else begin
      if (tick) prev <= line;
      if (!rx_en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (prev && !line) begin
              state <= RX_RECV;
              phase <= CW'(1);
              idx   <= '0;
            end
          end
          RX_RECV: begin
            phase <= (phase == CW'(OVS - 1)) ? '0 : phase + 1'b1;
            if (phase == CW'(OVS - 1)) idx <= idx + 1'b1;
            if (bit_rdy) begin
              if (idx == '0) begin
                if (bit_val) state <= RX_IDLE;
              end else if (idx == IW'(STOP_IDX)) begin
                state <= RX_IDLE;
              end else begin
                shreg <= {bit_val, shreg[DATA_W:1]};
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load_now) begin
        data_q <= shreg[DATA_W-1:0];
        bit9_q <= shreg[DATA_W];
        done_q <= 1'b1;
      end else if (done_clr) begin
        done_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial9_rx.sv
module serial9_rx #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              mp_filter,
  input  logic              done_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done
);
  localparam int CW = $clog2(OVS);

  logic          line_s;
  logic [CW-1:0] phase;
  logic          bit_rdy, bit_val;
  logic          rx_busy;

  serial9_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  serial9_rx_vote #(.OVS(OVS)) u_vote (
    .clk(clk), .rst(rst), .tick(sample_en), .phase(phase),
    .din(line_s), .bit_rdy(bit_rdy), .bit_val(bit_val)
  );

  serial9_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(sample_en), .rx_en(rx_en), .line(line_s),
    .mp_filter(mp_filter), .done_clr(done_clr), .bit_rdy(bit_rdy),
    .bit_val(bit_val), .phase(phase), .busy(rx_busy), .data_q(rx_data),
    .bit9_q(rx_bit9), .done_q(rx_done)
  );
endmodule

// File: rtl/serial9_rx_chk.sv
module serial9_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              done_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_done,
  input logic              rx_busy
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rx_data == '0 && !rx_bit9 && !rx_done));

  p_hold_full_r6: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> ($stable(rx_data) && $stable(rx_bit9)));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !done_clr) |=> rx_done);

  p_done_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && done_clr) |=> !rx_done);

  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_busy);

  p_load_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(rx_en));
endmodule

bind serial9_rx serial9_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .done_clr(done_clr),
  .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_busy(rx_busy)
);

// File: tb/serial9_rx_bench.sv
module serial9_rx_bench;
  localparam int OVS = 16;
  localparam int DW  = 8;
  localparam int LAT = 2 + 1 + 10 * OVS + OVS / 2 + 2;

  logic clk = 1'b0, rst = 1'b1, sample_en = 1'b0, rx_en = 1'b0;
  logic rxd = 1'b1, mp_filter = 1'b0, done_clr = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_bit9, rx_done;

  int checks = 0, failures = 0;
  int div = 1, divcnt = 0;
  int cyc = 0, rise_cyc = -1, start_cyc = 0;
  logic done_d = 1'b0;

  serial9_rx u_serial9_rx (
    .clk(clk), .rst(rst), .sample_en(sample_en), .rx_en(rx_en), .rxd(rxd),
    .mp_filter(mp_filter), .done_clr(done_clr), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_done(rx_done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    sample_en <= (divcnt == 0);
    divcnt    <= (divcnt + 1 >= div) ? 0 : divcnt + 1;
    if (rx_done && !done_d) rise_cyc <= cyc;
    done_d <= rx_done;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stop, input int gbit);
    logic [10:0] fr;
    fr = {stop, b9, d, 1'b0};
    start_cyc = cyc;
    for (int b = 0; b < 11; b++) begin
      for (int j = 0; j < OVS * div; j++) begin
        rxd = fr[b] ^ ((b == gbit) && (j == OVS / 2 + 1));
        @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (OVS * div) @(negedge clk);
  endtask

  task automatic clear_done();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    rx_en = 1'b1;
    @(negedge clk);
    chk("R1 data", int'(rx_data), 0);
    chk("R1 bit9", int'(rx_bit9), 0);
    chk("R1 done", int'(rx_done), 0);

    // R2 latency and R5 framing
    send(8'hA5, 1'b1, 1'b1, -1);
    chk("R2 latency", rise_cyc - start_cyc, LAT);
    chk("R5 data", int'(rx_data), 8'hA5);
    chk("R5 bit9", int'(rx_bit9), 1);
    repeat (30) @(negedge clk);
    chk("R8 sticky", int'(rx_done), 1);
    clear_done();
    chk("R8 clear", int'(rx_done), 0);

    // R5 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      send(8'(v), ^8'(v), 1'b1, -1);
      chk("R5 sweep", {23'd0, rx_bit9, rx_done, rx_data}, {23'd0, ^8'(v), 1'b1, 8'(v)});
      clear_done();
    end

    // R3 single-sample glitch on each data and ninth bit
    for (int g = 1; g <= 9; g++) begin
      send(8'h96, 1'b0, 1'b1, g);
      chk("R3 glitch", {23'd0, rx_bit9, rx_done, rx_data}, {23'd0, 1'b0, 1'b1, 8'h96});
      clear_done();
    end

    // R4 false start then a valid frame
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    chk("R4 no done", int'(rx_done), 0);
    chk("R4 data kept", int'(rx_data), 8'h96);
    send(8'h5A, 1'b0, 1'b1, -1);
    chk("R4 next frame", {24'd0, rx_data}, 8'h5A);
    chk("R4 next done", int'(rx_done), 1);
    clear_done();

    // R6 frame ignored while done is set
    send(8'h11, 1'b0, 1'b1, -1);
    send(8'h22, 1'b1, 1'b1, -1);
    chk("R6 data held", int'(rx_data), 8'h11);
    chk("R6 bit9 held", int'(rx_bit9), 0);
    clear_done();

    // R7 address filter
    mp_filter = 1'b1;
    send(8'h33, 1'b1, 1'b0, -1);
    chk("R7 discard done", int'(rx_done), 0);
    chk("R7 discard data", int'(rx_data), 8'h11);
    send(8'h44, 1'b1, 1'b1, -1);
    chk("R7 accept", {23'd0, rx_bit9, rx_done, rx_data}, {23'd0, 1'b1, 1'b1, 8'h44});
    clear_done();
    mp_filter = 1'b0;
    send(8'h55, 1'b0, 1'b0, -1);
    chk("R7 filter off", {23'd0, rx_bit9, rx_done, rx_data}, {23'd0, 1'b0, 1'b1, 8'h55});
    clear_done();

    // R9 enable gating
    rx_en = 1'b0;
    send(8'h66, 1'b1, 1'b1, -1);
    chk("R9 disabled done", int'(rx_done), 0);
    chk("R9 disabled data", int'(rx_data), 8'h55);
    rx_en = 1'b1;
    fork
      send(8'hFF, 1'b1, 1'b1, -1);
      begin
        repeat (80) @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
      end
    join
    chk("R9 abort done", int'(rx_done), 0);
    chk("R9 abort data", int'(rx_data), 8'h55);

    // R2 slower sample strobe
    div = 4;
    repeat (8) @(negedge clk);
    send(8'hC3, 1'b1, 1'b1, -1);
    chk("R2 slow tick", {23'd0, rx_bit9, rx_done, rx_data}, {23'd0, 1'b1, 1'b1, 8'hC3});
    clear_done();
    chk("R8 clear slow", int'(rx_done), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule